// File: doc/BRIEF.md
# External Interrupt Request Logic

This block gathers interrupt requests from a set of external interrupt pins and from a key-input port. Each external pin has its own active-edge choice, and each key pin has its own choice as well. When an active edge is seen on an external pin, that pin's request flag is latched. When an active edge is seen on any key pin, a single shared key request flag is latched. Software can read the request flags and clear them through a small register port. An enable mask decides which latched requests reach the single pending line that goes to the CPU.

All pins pass through a synchroniser before the edge detector. The detector compares each synchronised pin, XOR-ed with its edge-select bit, against the same value one cycle earlier. Because of this, rewriting an edge-select bit while the pin is static can latch a request on its own. Software that wants no interrupt from such a change follows a fixed sequence: disable the source, change the select, clear the request, then re-enable. The block does not encode priority and does not produce vectors.

Top module: `xirq_ctrl`

## Requirements
- R1: After reset, all four registers read zero and `irq_pending` is low.
- R2: Register address 0 holds the external edge selects. Bit i set to 0 makes a rising edge on `ext_pin[i]` active, and 1 makes a falling edge active. An active edge sets request bit i.
- R3: Register address 1 holds one edge-select bit per key pin, with the same 0 = rising, 1 = falling coding. An active edge on any key pin sets request bit NUM_EXT, the shared key flag.
- R4: A request flag sets even when its enable bit is 0, and `irq_pending` then stays low.
- R5: A write to register address 2 (the request flags, bit i for external source i and bit NUM_EXT for keys) clears each flag whose data bit is 0. Data bits of 1 leave their flags unchanged.
- R6: When a hardware set and a software clear of the same flag happen in the same cycle, the flag ends up set.
- R7: Register address 3 holds the enables, with the same bit layout as the requests. `irq_pending` is high exactly when some source is both requested and enabled.
- R8: With a pin held static, rewriting its edge-select bit so that pin XOR select goes from 0 to 1 sets the request. Going from 1 to 0 does not. Clearing the enable first, then changing the select, then clearing the request, then re-enabling leaves `irq_pending` low.
- R9: A request flag reads as set three rising clock edges after the pin change, and not after two.
- R10: An edge of the inactive polarity does not set the request flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | NUM_EXT | External interrupt pins |
| key_pin | input | KEY_W | Key-input port pins |
| reg_addr | input | 2 | Register select for both read and write |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr`, zero-extended |
| irq_pending | output | 1 | OR of all requested and enabled sources |

## Verification
The hardest case to reach from the ports is a hardware set and a software clear of the same flag landing in the same clock cycle. A pin edge arrives only after a synchroniser delay that is awkward to line up with a write. The stimulus therefore produces the set with an edge-select write on a static pin, which raises the detector output in the very next cycle. A request clear is issued back-to-back in that cycle. The same select-change mechanism is used to check the disable, change, clear, re-enable sequence. Separate sweeps cover every source and polarity, and every request/enable pair.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
   typedef enum logic [1:0] {
      XR_EXT_SEL = 2'd0,
      XR_KEY_SEL = 2'd1,
      XR_REQ     = 2'd2,
      XR_EN      = 2'd3
   } xirq_reg_e;
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("xirq_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("xirq_sync: W must be at least 1");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= '0;
      end else begin
         stg[0] <= din;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   assign dout = stg[STAGES-1];
endmodule

// File: rtl/xirq_edge.sv
module xirq_edge #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] sig,
   input  logic [W-1:0] sel,
   output logic [W-1:0] hit
);
   logic [W-1:0] lvl;
   logic [W-1:0] lvl_q;

   assign lvl = sig ^ sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= '0;
      else        lvl_q <= lvl;
   end

   assign hit = lvl & ~lvl_q;

   // R10: no detection while pin and select both hold still
   a_r10_quiet_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $stable(sig) && $stable(sel)) |-> (hit == '0));
endmodule

// File: rtl/xirq_req.sv
module xirq_req #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] hit,
   input  logic         clr_we,
   input  logic [N-1:0] clr_keep,
   output logic [N-1:0] req
);
   logic [N-1:0] req_nx;

   always_comb begin
      req_nx = req;
      if (clr_we) req_nx = req_nx & clr_keep;
      req_nx = req_nx | hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req <= '0;
      else        req <= req_nx;
   end

   // R6: a detected edge always lands in the flag, write or not
   a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (hit != '0) |=> ((req & $past(hit)) == $past(hit)));
   // R5: bits written as 0 are gone unless hardware set them
   a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> ((req & ~$past(clr_keep) & ~$past(hit)) == '0));
   // R4: flags only appear through a detected edge
   a_r4_set_only_by_hit: assert property (@(posedge clk) disable iff (!rst_n)
      ((req & ~$past(req) & ~$past(hit)) == '0));
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl #(
   parameter int NUM_EXT     = 2,
   parameter int KEY_W       = 8,
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EXT-1:0] ext_pin,
   input  logic [KEY_W-1:0]   key_pin,
   input  logic [1:0]         reg_addr,
   input  logic               reg_wr,
   input  logic [DW-1:0]      reg_wdata,
   output logic [DW-1:0]      reg_rdata,
   output logic               irq_pending
);
   import xirq_pkg::*;

   localparam int NSRC = NUM_EXT + 1;
   localparam int NPIN = NUM_EXT + KEY_W;

   if (NUM_EXT < 1) begin : g_bad_ext
      $error("xirq_ctrl: NUM_EXT must be at least 1");
   end
   if (DW < KEY_W || DW < NSRC) begin : g_bad_dw
      $error("xirq_ctrl: DW too narrow for the register contents");
   end

   xirq_reg_e          sel_reg;
   logic [NUM_EXT-1:0] ext_sel;
   logic [KEY_W-1:0]   key_sel;
   logic [NSRC-1:0]    en;
   logic [NSRC-1:0]    req;
   logic [NPIN-1:0]    pin_s;
   logic [NUM_EXT-1:0] ext_hit;
   logic [KEY_W-1:0]   key_hit;
   logic [NSRC-1:0]    src_hit;
   logic               req_we;

   assign sel_reg = xirq_reg_e'(reg_addr);
   assign req_we  = reg_wr && (sel_reg == XR_REQ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_sel <= '0;
         key_sel <= '0;
         en      <= '0;
      end else if (reg_wr) begin
         case (sel_reg)
            XR_EXT_SEL: ext_sel <= reg_wdata[NUM_EXT-1:0];
            XR_KEY_SEL: key_sel <= reg_wdata[KEY_W-1:0];
            XR_EN:      en      <= reg_wdata[NSRC-1:0];
            default:    ;
         endcase
      end
   end

   xirq_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({key_pin, ext_pin}),
      .dout (pin_s)
   );

   xirq_edge #(.W(NUM_EXT)) u_ext_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .sig  (pin_s[NUM_EXT-1:0]),
      .sel  (ext_sel),
      .hit  (ext_hit)
   );

   xirq_edge #(.W(KEY_W)) u_key_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .sig  (pin_s[NPIN-1:NUM_EXT]),
      .sel  (key_sel),
      .hit  (key_hit)
   );

   assign src_hit = {|key_hit, ext_hit};

   xirq_req #(.N(NSRC)) u_req (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (src_hit),
      .clr_we  (req_we),
      .clr_keep(reg_wdata[NSRC-1:0]),
      .req     (req)
   );

   always_comb begin
      reg_rdata = '0;
      case (sel_reg)
         XR_EXT_SEL: reg_rdata[NUM_EXT-1:0] = ext_sel;
         XR_KEY_SEL: reg_rdata[KEY_W-1:0]   = key_sel;
         XR_REQ:     reg_rdata[NSRC-1:0]    = req;
         XR_EN:      reg_rdata[NSRC-1:0]    = en;
         default:    reg_rdata = '0;
      endcase
   end

   assign irq_pending = |(req & en);

   // R7: a disabled source never drives the pending line on its own
   a_r7_pending_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (en == '0) |-> !irq_pending);
endmodule

// File: tb/sim_xirq_ctrl.sv
module sim_xirq_ctrl;
   localparam int PERIOD = 10;
   localparam int NE = 2;
   localparam int KW = 8;
   localparam int DW = 8;

   logic          clk = 0;
   logic          rst_n = 0;
   logic [NE-1:0] ext_pin = '0;
   logic [KW-1:0] key_pin = '0;
   logic [1:0]    reg_addr = '0;
   logic          reg_wr = 0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          irq_pending;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #(PERIOD/2) clk = ~clk;

   xirq_ctrl #(.NUM_EXT(NE), .KEY_W(KW), .DW(DW), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .key_pin(key_pin),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_pending(irq_pending));

   task automatic chk(input string tag, input int got, input int exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input int d);
      reg_addr  = a;
      reg_wdata = DW'(d);
      reg_wr    = 1;
      @(negedge clk);
      reg_wr    = 0;
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      reg_addr = a;
      #1;
      v = int'(reg_rdata);
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got 0 expected 1");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int v;
      cyc(3);
      rst_n = 1;
      cyc(2);
      // R1 reset state
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), v);
         chk("R1 reg reset", v, 0);
      end
      chk("R1 pending reset", int'(irq_pending), 0);

      // R2 / R10 / R4: each external source, each polarity
      for (int i = 0; i < NE; i++) begin
         for (int s = 0; s < 2; s++) begin
            wr(2'd0, s << i);
            ext_pin[i] = s[0];
            cyc(5);
            wr(2'd2, 0);
            rd(2'd2, v);
            chk("R2 setup clear", v, 0);
            ext_pin[i] = ~s[0];
            cyc(5);
            rd(2'd2, v);
            chk("R2 active edge sets flag", v, 1 << i);
            chk("R4 disabled source not pending", int'(irq_pending), 0);
            wr(2'd2, 0);
            ext_pin[i] = s[0];
            cyc(5);
            rd(2'd2, v);
            chk("R10 inactive edge ignored", v, 0);
            wr(2'd0, 0);
            ext_pin[i] = 1'b0;
            cyc(5);
            wr(2'd2, 0);
         end
      end

      // R3 / R10: each key pin, each polarity, shared flag bit NE
      for (int k = 0; k < KW; k++) begin
         for (int s = 0; s < 2; s++) begin
            wr(2'd1, s << k);
            key_pin[k] = s[0];
            cyc(5);
            wr(2'd2, 0);
            key_pin[k] = ~s[0];
            cyc(5);
            rd(2'd2, v);
            chk("R3 key edge sets shared flag", v, 1 << NE);
            wr(2'd2, 0);
            key_pin[k] = s[0];
            cyc(5);
            rd(2'd2, v);
            chk("R10 key inactive edge ignored", v, 0);
            wr(2'd1, 0);
            key_pin[k] = 1'b0;
            cyc(5);
            wr(2'd2, 0);
         end
      end

      // R9 latency: three edges after pin change
      cyc(2);
      ext_pin[1] = 1'b1;
      cyc(2);
      rd(2'd2, v);
      chk("R9 not yet after two edges", v, 0);
      @(negedge clk);
      rd(2'd2, v);
      chk("R9 set after three edges", v, 2);

      // R5: writing ones keeps flags, zeros clear
      ext_pin = '0;
      cyc(4);
      wr(2'd2, 0);
      ext_pin = '1;
      key_pin[0] = 1'b1;
      cyc(5);
      rd(2'd2, v);
      chk("R5 all three set", v, 7);
      wr(2'd2, 5);
      rd(2'd2, v);
      chk("R5 partial clear", v, 5);
      wr(2'd2, 0);
      wr(2'd2, 7);
      rd(2'd2, v);
      chk("R5 writing ones sets nothing", v, 0);

      // R7: every request/enable combination
      for (int r = 0; r < 8; r++) begin
         for (int e = 0; e < 8; e++) begin
            ext_pin = '0;
            key_pin = '0;
            cyc(4);
            wr(2'd2, 0);
            ext_pin = '1;
            key_pin[0] = 1'b1;
            cyc(5);
            wr(2'd2, r);
            wr(2'd3, e);
            chk("R7 pending OR of enabled requests", int'(irq_pending), int'((r & e) != 0));
         end
      end
      wr(2'd3, 0);
      ext_pin = '0;
      key_pin = '0;
      cyc(5);
      wr(2'd2, 0);

      // R8: select change on a static pin
      wr(2'd0, 1);
      cyc(2);
      rd(2'd2, v);
      chk("R8 select 0->1 on low pin sets flag", v, 1);
      wr(2'd2, 0);
      wr(2'd0, 0);
      cyc(2);
      rd(2'd2, v);
      chk("R8 select 1->0 on low pin no flag", v, 0);
      // safe sequence
      wr(2'd3, 1);
      wr(2'd3, 0);
      wr(2'd0, 1);
      cyc(2);
      wr(2'd2, 0);
      wr(2'd3, 1);
      cyc(2);
      rd(2'd2, v);
      chk("R8 safe sequence leaves flag clear", v, 0);
      chk("R8 safe sequence no pending", int'(irq_pending), 0);
      wr(2'd3, 0);
      wr(2'd0, 0);
      cyc(2);
      wr(2'd2, 0);

      // R6: hardware set collides with software clear
      wr(2'd0, 1);
      wr(2'd2, 0);
      rd(2'd2, v);
      chk("R6 set wins over clear", v, 1);
      wr(2'd2, 0);
      rd(2'd2, v);
      chk("R6 later clear works", v, 0);

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule